// File: doc/BRIEF.md
# PHY Status Auto-Poll Monitor

This block keeps a fresh copy of an external PHY's status register without software involvement. While polling is enabled it periodically asks the management frame master for a read of status register 1 at a configured PHY address. It stores each successful result in a shadow register and compares every later result with the stored copy. A difference sets a sticky change flag. Software can mask that flag from the interrupt output and clears it by writing one.

The block sits in front of the management frame master and shares it with host-initiated accesses. A waiting host access always goes before the next poll. A poll that has already started is always allowed to finish. A programmable interval spaces consecutive polls. Turning polling off stops new polls and forgets the first-read state, so the next enable starts with a load-only read.

Top module: `phy_autopoll_mon`

## Requirements
- R1: After reset, mgmtReq, hostGrant, chgFlag, intOut and shadowValid are 0 and shadowVal is 16'h0000.
- R2: No poll request (rising mgmtReq) is issued while pollEn is 0.
- R3: While mgmtReq is 1, mgmtPhyAddr equals phyAddr and mgmtRegAddr equals 5'd1. mgmtReq stays 1 until the cycle in which mgmtDone is 1.
- R4: With pollEn held at 1 and no host request, mgmtReq is 0 for exactly pollInterval+1 cycles between the completion of one poll and the next request.
- R5: The first successful read after polling is enabled loads shadowVal and sets shadowValid to 1. It never sets chgFlag.
- R6: A later successful read whose data differs from shadowVal sets chgFlag and updates shadowVal. A read with equal data leaves chgFlag unchanged.
- R7: A poll that completes with mgmtErr=1 leaves shadowVal, shadowValid and chgFlag unchanged.
- R8: chgFlag stays 1 until a cycle with chgClr=1 clears it. If a new change is detected in the same cycle as chgClr, the flag stays set.
- R9: intOut is 1 exactly when chgFlag is 1 and chgIntEn is 1.
- R10: When hostReq is 1 and no poll is in progress, hostGrant rises on the next cycle and no poll is issued while hostGrant is 1. A poll in progress is finished before hostGrant is given. hostGrant and mgmtReq are never both 1.
- R11: Clearing pollEn clears shadowValid on the next cycle. If a poll is in flight, it completes, but its data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pollEn | input | 1 | Auto-poll enable |
| chgIntEn | input | 1 | Change interrupt enable |
| chgClr | input | 1 | Write-one-to-clear strobe for chgFlag |
| phyAddr | input | 5 | PHY address to poll |
| pollInterval | input | 16 | Idle cycles between polls, minus one |
| hostReq | input | 1 | Host access waiting for the management master |
| hostGrant | output | 1 | Management master granted to the host |
| mgmtReq | output | 1 | Poll read request to the management master |
| mgmtPhyAddr | output | 5 | PHY address of the poll |
| mgmtRegAddr | output | 5 | Register address of the poll (status, 1) |
| mgmtDone | input | 1 | Poll completion pulse |
| mgmtErr | input | 1 | Completion ended in a read error |
| mgmtRdData | input | 16 | Read data at completion |
| shadowVal | output | 16 | Latest stored status value |
| shadowValid | output | 1 | Shadow holds a value from the current enable period |
| chgFlag | output | 1 | Sticky status-change flag |
| intOut | output | 1 | Masked change interrupt |

## Verification
Polls are run with repeated identical data, with data that changes, with data that changes back, and with errored completions. These patterns separate compare-and-set from load-only behaviour, and a stored value from one that is skipped. Interval values 4 and 0 show whether the spacing counter reloads and counts down correctly. A host request placed during a poll, and another placed while idle, show whether a poll is ever interrupted and whether the host wins. Turning polling off in the middle of a poll, then on again, shows whether the data of the in-flight poll is discarded and whether the first read after re-enable is load-only.

// File: rtl/phy_autopoll_pkg.sv
package phy_autopoll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POLL = 2'd1,
    ST_HOST = 2'd2
  } pollState_e;

  typedef struct packed {
    logic capture;
    logic dropFirst;
  } dpStrobe_t;
endpackage

// File: rtl/phy_autopoll_ctrl.sv
module phy_autopoll_ctrl
  import phy_autopoll_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pollEn,
  input  logic [CNT_W-1:0] pollInterval,
  input  logic             hostReq,
  input  logic             mgmtDone,
  input  logic             mgmtErr,
  output logic             mgmtReq,
  output logic             hostGrant,
  output dpStrobe_t        strb
);
  pollState_e state;
  logic [CNT_W-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      gapCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (hostReq) begin
            state <= ST_HOST;
          end else if (pollEn && gapCnt == '0) begin
            state <= ST_POLL;
          end else if (!pollEn) begin
            gapCnt <= '0;
          end else begin
            gapCnt <= gapCnt - 1'b1;
          end
        end
        ST_POLL: begin
          if (mgmtDone) begin
            state  <= ST_IDLE;
            gapCnt <= pollInterval;
          end
        end
        ST_HOST: begin
          if (!hostReq) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mgmtReq        = (state == ST_POLL);
    hostGrant      = (state == ST_HOST);
    strb.capture   = (state == ST_POLL) && mgmtDone && !mgmtErr && pollEn;
    strb.dropFirst = !pollEn;
  end

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(mgmtReq && hostGrant));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mgmtReq && !mgmtDone) |=> mgmtReq);

  // R2
  no_poll_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mgmtReq) |-> $past(pollEn));

  // R10
  host_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && !mgmtReq && !hostGrant) |=> hostGrant);
endmodule

// File: rtl/phy_autopoll_dp.sv
module phy_autopoll_dp
  import phy_autopoll_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] rdData,
  input  logic              chgClr,
  output logic [DATA_W-1:0] shadowVal,
  output logic              shadowValid,
  output logic              chgFlag
);
  logic diffHit;

  always_comb diffHit = strb.capture && shadowValid && (rdData != shadowVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowVal   <= '0;
      shadowValid <= 1'b0;
    end else if (strb.dropFirst) begin
      shadowValid <= 1'b0;
    end else if (strb.capture) begin
      shadowVal   <= rdData;
      shadowValid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        chgFlag <= 1'b0;
    else if (diffHit) chgFlag <= 1'b1;
    else if (chgClr)  chgFlag <= 1'b0;
  end

  // R5
  first_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !shadowValid && !chgFlag) |=> !chgFlag);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chgFlag && !chgClr) |=> chgFlag);

  // R11
  drop_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.dropFirst |=> !shadowValid);
endmodule

// File: rtl/phy_autopoll_mon.sv
module phy_autopoll_mon
  import phy_autopoll_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 5,
  parameter int CNT_W      = 16,
  parameter int STATUS_REG = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pollEn,
  input  logic              chgIntEn,
  input  logic              chgClr,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [CNT_W-1:0]  pollInterval,
  input  logic              hostReq,
  output logic              hostGrant,
  output logic              mgmtReq,
  output logic [ADDR_W-1:0] mgmtPhyAddr,
  output logic [ADDR_W-1:0] mgmtRegAddr,
  input  logic              mgmtDone,
  input  logic              mgmtErr,
  input  logic [DATA_W-1:0] mgmtRdData,
  output logic [DATA_W-1:0] shadowVal,
  output logic              shadowValid,
  output logic              chgFlag,
  output logic              intOut
);
  localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(STATUS_REG);

  dpStrobe_t strb;

  phy_autopoll_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .pollEn(pollEn), .pollInterval(pollInterval),
    .hostReq(hostReq), .mgmtDone(mgmtDone), .mgmtErr(mgmtErr),
    .mgmtReq(mgmtReq), .hostGrant(hostGrant), .strb(strb)
  );

  phy_autopoll_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdData(mgmtRdData),
    .chgClr(chgClr), .shadowVal(shadowVal), .shadowValid(shadowValid),
    .chgFlag(chgFlag)
  );

  always_comb begin
    mgmtPhyAddr = phyAddr;
    mgmtRegAddr = REG_ADDR;
    intOut      = chgFlag && chgIntEn;
  end

  // R7
  err_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mgmtReq && mgmtDone && mgmtErr) |=> ($stable(shadowVal) && $stable(chgFlag)));
endmodule

// File: tb/phy_autopoll_mon_tb_top.sv
module phy_autopoll_mon_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pollEn = 1'b0, chgIntEn = 1'b0, chgClr = 1'b0, hostReq = 1'b0;
  logic [4:0] phyAddr = 5'd0;
  logic [15:0] pollInterval = 16'd4;
  logic hostGrant, mgmtReq, shadowValid, chgFlag, intOut;
  logic [4:0] mgmtPhyAddr, mgmtRegAddr;
  logic mgmtDone = 1'b0, mgmtErr = 1'b0;
  logic [15:0] mgmtRdData = 16'h0, shadowVal;

  int checks = 0, failures = 0;
  int pollCount = 0, doneCnt = 0, lowCnt = 0, lastGap = 0, latCnt = 0, cyc = 0;
  logic prevReq = 1'b0;
  logic [15:0] phyData = 16'h0;
  logic respErr = 1'b0;
  logic [4:0] seenAddr = 5'd0, seenReg = 5'd0;
  localparam int LAT = 3;

  always #10 clk = ~clk;

  phy_autopoll_mon dut_i (
    .clk(clk), .rstN(rstN), .pollEn(pollEn), .chgIntEn(chgIntEn), .chgClr(chgClr),
    .phyAddr(phyAddr), .pollInterval(pollInterval), .hostReq(hostReq),
    .hostGrant(hostGrant), .mgmtReq(mgmtReq), .mgmtPhyAddr(mgmtPhyAddr),
    .mgmtRegAddr(mgmtRegAddr), .mgmtDone(mgmtDone), .mgmtErr(mgmtErr),
    .mgmtRdData(mgmtRdData), .shadowVal(shadowVal), .shadowValid(shadowValid),
    .chgFlag(chgFlag), .intOut(intOut)
  );

  // PHY-side responder of the management master, driven at negedge
  always @(negedge clk) begin
    cyc++;
    if (mgmtDone) begin
      mgmtDone = 1'b0;
    end else if (mgmtReq && rstN) begin
      if (latCnt == LAT) begin
        mgmtDone = 1'b1;
        mgmtErr = respErr;
        mgmtRdData = phyData;
        latCnt = 0;
        doneCnt++;
      end else latCnt++;
    end
    if (mgmtReq && !prevReq) begin
      pollCount++;
      lastGap = lowCnt;
      lowCnt = 0;
      seenAddr = mgmtPhyAddr;
      seenReg = mgmtRegAddr;
    end
    if (!mgmtReq) lowCnt++;
    prevReq = mgmtReq;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // wait for n more completions, then let results settle
  task automatic waitPolls(input int n);
    int target = doneCnt + n;
    int guard = 0;
    while (doneCnt < target && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 2000) chk("TIMEOUT", 1, 0);
    cycles(2);
  endtask

  task automatic t_reset();
    cycles(3);
    chk("R1 mgmtReq", mgmtReq, 0);
    chk("R1 hostGrant", hostGrant, 0);
    chk("R1 chgFlag", chgFlag, 0);
    chk("R1 intOut", intOut, 0);
    chk("R1 shadowValid", shadowValid, 0);
    chk("R1 shadowVal", shadowVal, 0);
  endtask

  task automatic t_disabled();
    phyAddr = 5'd9;
    cycles(50);
    chk("R2 no poll while disabled", pollCount, 0);
  endtask

  task automatic t_first();
    phyData = 16'h7809;
    pollEn = 1'b1;
    waitPolls(1);
    chk("R3 phy addr", seenAddr, 5'd9);
    chk("R3 reg addr", seenReg, 5'd1);
    chk("R5 shadow loaded", shadowVal, 16'h7809);
    chk("R5 valid", shadowValid, 1);
    chk("R5 no flag on first", chgFlag, 0);
  endtask

  task automatic t_same();
    waitPolls(2);
    chk("R6 equal data no flag", chgFlag, 0);
    chk("R4 gap interval 4", lastGap, 5);
  endtask

  task automatic t_change();
    phyData = 16'h780D;
    waitPolls(1);
    chk("R6 change sets flag", chgFlag, 1);
    chk("R6 shadow updated", shadowVal, 16'h780D);
    chk("R9 masked", intOut, 0);
    chgIntEn = 1'b1;
    @(negedge clk);
    chk("R9 unmasked", intOut, 1);
  endtask

  task automatic t_sticky();
    waitPolls(2);
    chk("R8 sticky", chgFlag, 1);
    chgClr = 1'b1;
    @(negedge clk);
    chgClr = 1'b0;
    chk("R8 cleared", chgFlag, 0);
    chk("R9 follows flag", intOut, 0);
  endtask

  task automatic t_error();
    respErr = 1'b1;
    phyData = 16'h1234;
    waitPolls(2);
    chk("R7 shadow kept", shadowVal, 16'h780D);
    chk("R7 flag kept", chgFlag, 0);
    chk("R7 valid kept", shadowValid, 1);
    respErr = 1'b0;
    phyData = 16'h780D;
  endtask

  task automatic t_gap0();
    pollInterval = 16'd0;
    waitPolls(3);
    chk("R4 gap interval 0", lastGap, 1);
    pollInterval = 16'd4;
    waitPolls(2);
  endtask

  task automatic t_host();
    int guard = 0;
    int pc;
    while (!mgmtReq && guard < 100) begin @(negedge clk); guard++; end
    hostReq = 1'b1;
    @(negedge clk);
    chk("R10 poll not interrupted", mgmtReq, 1);
    chk("R10 no grant during poll", hostGrant, 0);
    guard = 0;
    while (!hostGrant && guard < 100) begin @(negedge clk); guard++; end
    chk("R10 grant after poll", hostGrant, 1);
    pc = pollCount;
    pollInterval = 16'd0;
    cycles(20);
    chk("R10 no poll while granted", pollCount, pc);
    hostReq = 1'b0;
    waitPolls(1);
    // while idle between polls, host wins
    pollInterval = 16'd6;
    waitPolls(1);
    hostReq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 grant from idle", hostGrant, 1);
    cycles(10);
    chk("R10 still no request", mgmtReq, 0);
    hostReq = 1'b0;
    pollInterval = 16'd4;
    cycles(2);
  endtask

  task automatic t_disable();
    int guard = 0;
    while (!mgmtReq && guard < 100) begin @(negedge clk); guard++; end
    phyData = 16'hAAAA;
    pollEn = 1'b0;
    @(negedge clk);
    chk("R11 valid dropped", shadowValid, 0);
    cycles(10);
    chk("R11 in-flight data discarded", shadowVal, 16'h780D);
    chk("R11 no flag", chgFlag, 0);
    pollEn = 1'b1;
    waitPolls(1);
    chk("R5 reload after enable", shadowVal, 16'hAAAA);
    chk("R5 no flag on reload", chgFlag, 0);
  endtask

  initial begin
    cycles(4);
    rstN = 1'b1;
    t_reset();
    t_disabled();
    t_first();
    t_same();
    t_change();
    t_sticky();
    t_error();
    t_gap0();
    t_host();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule